// File: doc/BRIEF.md
# Floating-Point and Vector Status CSR Unit

This block keeps the architectural status state that the floating-point and vector units share with software. It stores the floating-point exception flags, the floating-point rounding mode, the vector fixed-point rounding mode, the vector saturation flag and the vector start index. It also serves read-only views of the current vector length, the vector type with its illegal-configuration flag, and the vector register length in bytes. Two composite registers overlay the separate fields. A composite holds no state of its own. It reads and writes the same storage as the separate registers it covers.

A single access port carries an address, a valid strobe, a write enable and write data. On the clock edge that takes an access, the block registers the value the addressed register held before the write, together with an illegal-access flag. A legal write to floating-point state raises a one-cycle request that the status register mark the floating-point state dirty. A legal write to vector state raises the matching request for the vector state. The vector length, the vector type and the illegal-type flag come in from the vector configuration logic and are only reflected here.

Top module: `fpv_csr_unit`

## Requirements
- R1: After synchronous reset every stored field is zero, and the read data, illegal flag and both dirty requests are low.
- R2: The composite FP register (address 0x003) reads the exception flags in bits 4:0 and the rounding mode in bits 7:5. A write to it updates both fields from those bit positions.
- R3: A write to the exception-flag register (0x001) keeps only write-data bits 4:0. A write to the rounding-mode register (0x002) keeps only bits 2:0. Each of these writes leaves the other field unchanged.
- R4: A legal write to 0x001, 0x002 or 0x003 raises `fs_dirty` for exactly the cycle after the access. This happens only when the F parameter is set. Reads never raise it.
- R5: An FP register access is illegal when `fp_enable` and `dbg_mode` are both low, unless the FP-in-integer-registers parameter is set. An illegal access changes no state and raises no dirty request. Debugger accesses are legal.
- R6: The composite vector register (0x00F) reads the saturation flag in bit 0 and the fixed-point rounding mode in bits 2:1. A write to it updates both. A write to the saturation register (0x009) keeps bit 0. A write to the rounding register (0x00A) keeps bits 1:0. Each of these writes leaves the other field unchanged.
- R7: A legal write to 0x008, 0x009, 0x00A or 0x00F raises `vs_dirty` for exactly the cycle after the access.
- R8: A write to the start-index register (0x008) keeps only the low log2(VLEN) bits. All higher bits read back as zero.
- R9: Address 0xC22 reads VLEN/8. Address 0xC20 reads `vl_in`.
- R10: Address 0xC21 reads `vtype_in` with `vill_in` placed in bit 63 when `xlen64` is high, or in bit 31 when it is low. All other upper bits are zero.
- R11: A write to 0xC20, 0xC21 or 0xC22 is illegal. Any access to an address not listed here is illegal. Neither changes state, and neither raises a dirty request.
- R12: The read data of an access that also writes is the value the register held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_valid | input | 1 | Access strobe |
| csr_we | input | 1 | Access also writes |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| fp_enable | input | 1 | FP state enabled in the status register |
| dbg_mode | input | 1 | Access comes from the debugger |
| xlen64 | input | 1 | 1 selects the 64-bit register view |
| vl_in | input | VL_W | Current vector length |
| vtype_in | input | VTYPE_W | Current vector type |
| vill_in | input | 1 | Vector type is illegal |
| csr_rdata | output | XLEN | Registered read data (pre-write value) |
| csr_illegal | output | 1 | Registered illegal-access flag |
| fs_dirty | output | 1 | One-cycle request to mark FP state dirty |
| vs_dirty | output | 1 | One-cycle request to mark vector state dirty |

## Verification
The bench writes all-ones patterns to each narrow register. A design that fails to mask the writes returns stray high bits, or a start index wider than log2(VLEN). Writes go through one alias and reads through the other alias, and the bench confirms that each single-field write leaves its neighbour intact. A design with separate alias storage, or with shifted composite fields, therefore reads back stale or misplaced values. The bench drives a blocked FP access, a debugger override, read-only writes and an unknown address, and checks that none changes state or raises a dirty request. It also places the illegal-type flag in both register widths, where a fixed bit position fails one of the two views.

// File: rtl/fpv_csr_pkg.sv
package fpv_csr_pkg;
  localparam logic [11:0] A_FFLAGS = 12'h001;
  localparam logic [11:0] A_FRM    = 12'h002;
  localparam logic [11:0] A_FCSR   = 12'h003;
  localparam logic [11:0] A_VSTART = 12'h008;
  localparam logic [11:0] A_VXSAT  = 12'h009;
  localparam logic [11:0] A_VXRM   = 12'h00A;
  localparam logic [11:0] A_VCSR   = 12'h00F;
  localparam logic [11:0] A_VL     = 12'hC20;
  localparam logic [11:0] A_VTYPE  = 12'hC21;
  localparam logic [11:0] A_VLENB  = 12'hC22;

  localparam int unsigned FFLAGS_W = 5;
  localparam int unsigned FRM_W    = 3;
  localparam int unsigned VXRM_W   = 2;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_FFLAGS, SEL_FRM, SEL_FCSR,
    SEL_VSTART, SEL_VXSAT, SEL_VXRM, SEL_VCSR,
    SEL_VL, SEL_VTYPE, SEL_VLENB
  } csr_sel_e;
endpackage

// File: rtl/fpv_csr_decode.sv
module fpv_csr_decode
  import fpv_csr_pkg::*;
#(
  parameter bit HAS_F      = 1'b1,
  parameter bit FP_IN_XREG = 1'b0
) (
  input  logic [11:0] addr,
  input  logic        we,
  input  logic        fp_enable,
  input  logic        dbg_mode,
  output csr_sel_e    sel,
  output logic        illegal,
  output logic        fp_wr_ok,
  output logic        vec_wr_ok,
  output logic        fs_mark
);
  logic is_fp, is_vec_rw, is_ro, fp_ok;

  always_comb begin
    case (addr)
      A_FFLAGS: sel = SEL_FFLAGS;
      A_FRM:    sel = SEL_FRM;
      A_FCSR:   sel = SEL_FCSR;
      A_VSTART: sel = SEL_VSTART;
      A_VXSAT:  sel = SEL_VXSAT;
      A_VXRM:   sel = SEL_VXRM;
      A_VCSR:   sel = SEL_VCSR;
      A_VL:     sel = SEL_VL;
      A_VTYPE:  sel = SEL_VTYPE;
      A_VLENB:  sel = SEL_VLENB;
      default:  sel = SEL_NONE;
    endcase
  end

  assign is_fp     = (sel == SEL_FFLAGS) || (sel == SEL_FRM) || (sel == SEL_FCSR);
  assign is_vec_rw = (sel == SEL_VSTART) || (sel == SEL_VXSAT) ||
                     (sel == SEL_VXRM)   || (sel == SEL_VCSR);
  assign is_ro     = (sel == SEL_VL) || (sel == SEL_VTYPE) || (sel == SEL_VLENB);
  assign fp_ok     = fp_enable || dbg_mode || FP_IN_XREG;

  assign illegal   = (sel == SEL_NONE) || (is_fp && !fp_ok) || (is_ro && we);
  assign fp_wr_ok  = we && is_fp && fp_ok;
  assign vec_wr_ok = we && is_vec_rw;
  assign fs_mark   = fp_wr_ok && HAS_F;
endmodule

// File: rtl/fpv_fp_state.sv
module fpv_fp_state
  import fpv_csr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  csr_sel_e            sel,
  input  logic [7:0]          wdata,
  output logic [FFLAGS_W-1:0] fflags,
  output logic [FRM_W-1:0]    frm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fflags <= '0;
      frm    <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_FFLAGS: fflags <= wdata[FFLAGS_W-1:0];
        SEL_FRM:    frm    <= wdata[FRM_W-1:0];
        SEL_FCSR: begin
          fflags <= wdata[FFLAGS_W-1:0];
          frm    <= wdata[FFLAGS_W +: FRM_W];
        end
        default: ;
      endcase
    end
  end

  // R3: single-field writes leave the neighbour untouched
  a_r3_frm_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && sel == SEL_FRM) |-> $stable(fflags));
  a_r3_flags_keep_frm: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && sel == SEL_FFLAGS) |-> $stable(frm));
  // R5: no write strobe, no change
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    $past(!wr_en) |-> $stable({frm, fflags}));
endmodule

// File: rtl/fpv_vec_state.sv
module fpv_vec_state
  import fpv_csr_pkg::*;
#(
  parameter int unsigned VSTART_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  csr_sel_e            sel,
  input  logic [VSTART_W-1:0] wdata,
  output logic [VXRM_W-1:0]   vxrm,
  output logic                vxsat,
  output logic [VSTART_W-1:0] vstart
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vxrm   <= '0;
      vxsat  <= 1'b0;
      vstart <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_VSTART: vstart <= wdata;
        SEL_VXSAT:  vxsat  <= wdata[0];
        SEL_VXRM:   vxrm   <= wdata[VXRM_W-1:0];
        SEL_VCSR: begin
          vxsat <= wdata[0];
          vxrm  <= wdata[1 +: VXRM_W];
        end
        default: ;
      endcase
    end
  end

  // R6: single-field writes leave the neighbour untouched
  a_r6_vxrm_keeps_sat: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && sel == SEL_VXRM) |-> $stable(vxsat));
  // R8: start index takes the low bits of the write
  a_r8_vstart_low_bits: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && sel == SEL_VSTART) |-> vstart == $past(wdata));
endmodule

// File: rtl/fpv_csr_unit.sv
module fpv_csr_unit
  import fpv_csr_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned VLEN       = 128,
  parameter int unsigned VTYPE_W    = 8,
  parameter bit          HAS_F      = 1'b1,
  parameter bit          FP_IN_XREG = 1'b0,
  localparam int unsigned VSTART_W  = $clog2(VLEN),
  localparam int unsigned VL_W      = $clog2(VLEN) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                csr_valid,
  input  logic                csr_we,
  input  logic [11:0]         csr_addr,
  input  logic [XLEN-1:0]     csr_wdata,
  input  logic                fp_enable,
  input  logic                dbg_mode,
  input  logic                xlen64,
  input  logic [VL_W-1:0]     vl_in,
  input  logic [VTYPE_W-1:0]  vtype_in,
  input  logic                vill_in,
  output logic [XLEN-1:0]     csr_rdata,
  output logic                csr_illegal,
  output logic                fs_dirty,
  output logic                vs_dirty
);
  localparam int unsigned WUSE = (VSTART_W > 8) ? VSTART_W : 8;

  csr_sel_e              sel;
  logic                  illegal, fp_wr_ok, vec_wr_ok, fs_mark;
  logic [FFLAGS_W-1:0]   fflags;
  logic [FRM_W-1:0]      frm;
  logic [VXRM_W-1:0]     vxrm;
  logic                  vxsat;
  logic [VSTART_W-1:0]   vstart;
  logic [XLEN-1:0]       rd_val, vt_view;

  generate
    if (XLEN > WUSE) begin : g_unused
      logic unused_hi;
      assign unused_hi = ^csr_wdata[XLEN-1:WUSE];
    end
  endgenerate

  fpv_csr_decode #(.HAS_F(HAS_F), .FP_IN_XREG(FP_IN_XREG)) u_dec (
    .addr(csr_addr), .we(csr_we), .fp_enable(fp_enable), .dbg_mode(dbg_mode),
    .sel(sel), .illegal(illegal), .fp_wr_ok(fp_wr_ok),
    .vec_wr_ok(vec_wr_ok), .fs_mark(fs_mark)
  );

  fpv_fp_state u_fp (
    .clk(clk), .rst(rst), .wr_en(csr_valid && fp_wr_ok), .sel(sel),
    .wdata(csr_wdata[7:0]), .fflags(fflags), .frm(frm)
  );

  fpv_vec_state #(.VSTART_W(VSTART_W)) u_vec (
    .clk(clk), .rst(rst), .wr_en(csr_valid && vec_wr_ok), .sel(sel),
    .wdata(csr_wdata[VSTART_W-1:0]), .vxrm(vxrm), .vxsat(vxsat), .vstart(vstart)
  );

  generate
    if (XLEN == 64) begin : g_vt64
      always_comb begin
        vt_view = XLEN'(vtype_in);
        if (xlen64) vt_view[63] = vill_in;
        else        vt_view[31] = vill_in;
      end
    end else begin : g_vt32
      logic unused_xl;
      assign unused_xl = xlen64;
      always_comb begin
        vt_view = XLEN'(vtype_in);
        vt_view[XLEN-1] = vill_in;
      end
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_FFLAGS: rd_val = XLEN'(fflags);
      SEL_FRM:    rd_val = XLEN'(frm);
      SEL_FCSR:   rd_val = XLEN'({frm, fflags});
      SEL_VSTART: rd_val = XLEN'(vstart);
      SEL_VXSAT:  rd_val = XLEN'(vxsat);
      SEL_VXRM:   rd_val = XLEN'(vxrm);
      SEL_VCSR:   rd_val = XLEN'({vxrm, vxsat});
      SEL_VL:     rd_val = XLEN'(vl_in);
      SEL_VTYPE:  rd_val = vt_view;
      SEL_VLENB:  rd_val = XLEN'(VLEN / 8);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata   <= '0;
      csr_illegal <= 1'b0;
      fs_dirty    <= 1'b0;
      vs_dirty    <= 1'b0;
    end else begin
      fs_dirty <= csr_valid && fs_mark;
      vs_dirty <= csr_valid && vec_wr_ok;
      if (csr_valid) begin
        csr_rdata   <= illegal ? '0 : rd_val;
        csr_illegal <= illegal;
      end
    end
  end

  // R4: FP dirty request only follows a write access
  a_r4_fs_after_write: assert property (@(posedge clk) disable iff (rst)
    fs_dirty |-> $past(csr_valid && csr_we));
  // R7: vector dirty request only follows a write access
  a_r7_vs_after_write: assert property (@(posedge clk) disable iff (rst)
    vs_dirty |-> $past(csr_valid && csr_we));
  // R11: an illegal access never marks state dirty
  a_r11_illegal_no_dirty: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |-> !fs_dirty && !vs_dirty);
  // R10: illegal-type flag lands in the top bit of the wide view
  a_r10_vill_msb: assert property (@(posedge clk) disable iff (rst)
    (csr_valid && !csr_we && csr_addr == A_VTYPE && vill_in && xlen64)
      |=> csr_rdata[XLEN-1]);
endmodule

// File: tb/sim_fpv_csr_unit.sv
module sim_fpv_csr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int VLEN = 128;
  localparam int VL_W = $clog2(VLEN) + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic csr_valid = 0, csr_we = 0, fp_enable = 1, dbg_mode = 0, xlen64 = 1, vill_in = 0;
  logic [11:0] csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [VL_W-1:0] vl_in = '0;
  logic [7:0] vtype_in = '0;
  logic [XLEN-1:0] csr_rdata;
  logic csr_illegal, fs_dirty, vs_dirty;

  int n_chk = 0, n_bad = 0;
  logic [XLEN-1:0] r_data;
  logic r_ill, r_fs, r_vs;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpv_csr_unit u0 (
    .clk(clk), .rst(rst), .csr_valid(csr_valid), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .fp_enable(fp_enable),
    .dbg_mode(dbg_mode), .xlen64(xlen64), .vl_in(vl_in), .vtype_in(vtype_in),
    .vill_in(vill_in), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .fs_dirty(fs_dirty), .vs_dirty(vs_dirty)
  );

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic acc(logic [11:0] a, logic w, logic [XLEN-1:0] d);
    @(negedge clk);
    csr_valid = 1; csr_we = w; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    r_data = csr_rdata; r_ill = csr_illegal; r_fs = fs_dirty; r_vs = vs_dirty;
    csr_valid = 0; csr_we = 0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", csr_rdata, 0);
    chk("R1 dirty", {62'd0, fs_dirty, vs_dirty}, 0);
    acc(12'h003, 0, 0); chk("R1 fcsr", r_data, 0);
    acc(12'h00F, 0, 0); chk("R1 vcsr", r_data, 0);
  endtask

  task automatic t_fp_fields();
    acc(12'h001, 1, '1); chk("R4 fs pulse", r_fs, 1); chk("R4 no vs", r_vs, 0);
    @(negedge clk); chk("R4 one cycle", fs_dirty, 0);
    acc(12'h001, 0, 0); chk("R3 fflags mask", r_data, 64'h1F); chk("R4 read no pulse", r_fs, 0);
    acc(12'h002, 1, '1); acc(12'h002, 0, 0); chk("R3 frm mask", r_data, 7);
    acc(12'h001, 0, 0); chk("R3 fflags kept", r_data, 64'h1F);
    acc(12'h003, 0, 0); chk("R2 fcsr read", r_data, 64'hFF);
    acc(12'h003, 1, 64'h5A); chk("R12 old value", r_data, 64'hFF);
    acc(12'h001, 0, 0); chk("R2 fcsr flags", r_data, 64'h1A);
    acc(12'h002, 0, 0); chk("R2 fcsr frm", r_data, 2);
  endtask

  task automatic t_fp_gate();
    fp_enable = 0;
    acc(12'h003, 0, 0); chk("R5 read illegal", r_ill, 1);
    acc(12'h001, 1, 0); chk("R5 write illegal", r_ill, 1); chk("R5 no pulse", r_fs, 0);
    dbg_mode = 1;
    acc(12'h002, 1, 5); chk("R5 dbg legal", r_ill, 0); chk("R5 dbg pulse", r_fs, 1);
    dbg_mode = 0; fp_enable = 1;
    acc(12'h001, 0, 0); chk("R5 flags intact", r_data, 64'h1A);
    acc(12'h002, 0, 0); chk("R5 dbg frm", r_data, 5);
  endtask

  task automatic t_vec_fields();
    acc(12'h00F, 1, 7); chk("R7 vcsr pulse", r_vs, 1); chk("R7 no fs", r_fs, 0);
    acc(12'h00A, 0, 0); chk("R6 vxrm", r_data, 3);
    acc(12'h009, 0, 0); chk("R6 vxsat", r_data, 1);
    acc(12'h00A, 1, 64'hFE); chk("R7 vxrm pulse", r_vs, 1);
    acc(12'h00F, 0, 0); chk("R6 vcsr after vxrm", r_data, 5);
    acc(12'h009, 1, 2); chk("R7 vxsat pulse", r_vs, 1);
    acc(12'h00F, 0, 0); chk("R6 vcsr after vxsat", r_data, 4);
    acc(12'h008, 1, 64'hFFFF); chk("R7 vstart pulse", r_vs, 1);
    acc(12'h008, 0, 0); chk("R8 vstart mask", r_data, 64'h7F);
  endtask

  task automatic t_ro_views();
    acc(12'hC22, 0, 0); chk("R9 vlenb", r_data, VLEN/8);
    vl_in = 37; acc(12'hC20, 0, 0); chk("R9 vl", r_data, 37);
    vtype_in = 8'h43; vill_in = 1; xlen64 = 1;
    acc(12'hC21, 0, 0); chk("R10 vtype64", r_data, 64'h8000_0000_0000_0043);
    xlen64 = 0;
    acc(12'hC21, 0, 0); chk("R10 vtype32", r_data, 64'h8000_0043);
    vill_in = 0; xlen64 = 1;
    acc(12'hC21, 0, 0); chk("R10 no vill", r_data, 64'h43);
  endtask

  task automatic t_illegal();
    acc(12'hC20, 1, 5); chk("R11 ro write", r_ill, 1); chk("R11 no pulse", {r_fs, r_vs}, 0);
    acc(12'h123, 1, 0); chk("R11 unknown", r_ill, 1);
    acc(12'h008, 0, 0); chk("R11 vstart kept", r_data, 64'h7F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_fp_fields();
    t_fp_gate();
    t_vec_fields();
    t_ro_views();
    t_illegal();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule